// File: doc/BRIEF.md
# Eight-Window Register Bus Decoder

This block sits between a single master on a simple word-wide register bus and eight slave register blocks. A master request carries a 32-bit address, 32-bit write data, a 4-bit byte-lane select and one-cycle write or read strobes. The decoder compares the upper address bits with a fixed region tag. In the same cycle it raises the strobe on exactly one slave port, and it sends address, data and lane select to every port unchanged. Each slave decodes its own registers from the lower 20 address bits.

After the strobe the decoder remembers which port it picked. It waits for that port's acknowledge and returns the port's read data, error and acknowledge to the master one clock later. A parameter can mark any slot as unused. For such a slot the decoder ignores whatever the port wires carry and answers on its own with zero data, no error and an acknowledge. An address outside the region gets an error answer from the decoder, so the master never waits forever.

Top module: `sysbus_window_decoder`

## Requirements
- R1: An address whose bits [31:23] equal 9'h080 (range 0x40000000 to 0x407FFFFF) selects port n = address bits [22:20]. In the same cycle as the master strobe, a write strobe appears on p_wen[n] and a read strobe on p_ren[n].
- R2: Every port other than the selected one sees p_wen and p_ren low, and all port strobes are low when the master has no strobe.
- R3: p_addr, p_wdata and p_sel equal m_addr, m_wdata and m_sel in the same cycle, on all ports.
- R4: If the selected port acknowledges in the cycle after the strobe, m_ack rises one clock later, i.e. two clocks after the strobe edge. m_rdata then equals bits n*32+31 down to n*32 of p_rdata.
- R5: A slave may add wait states. An acknowledge k clocks after the strobe edge gives m_ack k+1 clocks after it. Acknowledges from other ports are ignored while waiting.
- R6: A slot whose PORT_USED bit is 0 (ports 5 and 7 by default) never gets a strobe, and its p_rdata, p_err and p_ack inputs are ignored. A request to it returns m_ack=1, m_err=0 and m_rdata=0 two clocks after the strobe edge.
- R7: An address outside the region raises no port strobe. It returns m_ack=1, m_err=1 and m_rdata=0 two clocks after the strobe edge.
- R8: m_ack is high for exactly one cycle per request. Outside that cycle m_err is 0 and m_rdata is 0.
- R9: A synchronous active-high rst drops any pending request and holds m_ack, m_err and m_rdata at zero. A late acknowledge after reset produces no m_ack.
- R10: m_err during the acknowledge cycle equals the selected port's p_err bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | 32 | Master byte address, held until m_ack |
| m_wdata | input | 32 | Master write data |
| m_sel | input | 4 | Master byte-lane select |
| m_wen | input | 1 | Master write strobe, one cycle |
| m_ren | input | 1 | Master read strobe, one cycle |
| m_rdata | output | 32 | Returned read data |
| m_err | output | 1 | Returned error flag |
| m_ack | output | 1 | Returned acknowledge pulse |
| p_addr | output | 32 | Address to all ports |
| p_wdata | output | 32 | Write data to all ports |
| p_sel | output | 4 | Byte-lane select to all ports |
| p_wen | output | 8 | Per-port write strobe |
| p_ren | output | 8 | Per-port read strobe |
| p_rdata | input | 256 | Packed read data, port n at bits n*32+31:n*32 |
| p_err | input | 8 | Per-port error |
| p_ack | input | 8 | Per-port acknowledge |

## Verification
The hardest case to reach is a port that stretches its answer while other ports wave stray acknowledges. A naive decoder would finish early on a foreign acknowledge, and ports only acknowledge after their own strobe. The bench's slave models therefore take a per-request latency of one to four clocks. A noise mask forces acknowledges on unselected and unused ports during the wait. The same mask is applied just after a mid-request reset, to show the lost request never completes.

// File: rtl/sysbus_dec_pkg.sv
package sysbus_dec_pkg;
  localparam int unsigned BUS_W       = 32;
  localparam int unsigned DEF_PORTS   = 8;
  localparam int unsigned DEF_WIN_LSB = 20;
  localparam logic [BUS_W-1:0] DEF_REGION = 32'h4000_0000;
  localparam logic [DEF_PORTS-1:0] DEF_USED = 8'b0101_1111;
endpackage

// File: rtl/sbd_window_match.sv
module sbd_window_match #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned WIN_LSB = 20,
  parameter logic [ADDR_W-1:0] REGION = 32'h4000_0000,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned TAG_LSB = WIN_LSB + IDX_W
) (
  input  logic [ADDR_W-1:WIN_LSB] addr_hi,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic tag_ok;

  always_comb begin
    tag_ok = (addr_hi[ADDR_W-1:TAG_LSB] == REGION[ADDR_W-1:TAG_LSB]);
    idx    = addr_hi[TAG_LSB-1:WIN_LSB];
    hit    = tag_ok && (int'(idx) < int'(N_PORTS));
  end
endmodule

// File: rtl/sbd_port_fanout.sv
module sbd_port_fanout #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 3,
  parameter logic [N_PORTS-1:0] PORT_USED = '1,
  localparam int unsigned P_W = N_PORTS * DATA_W
) (
  input  logic               wen,
  input  logic               ren,
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [P_W-1:0]     p_rdata,
  input  logic [N_PORTS-1:0] p_err,
  input  logic [N_PORTS-1:0] p_ack,
  output logic [N_PORTS-1:0] p_wen,
  output logic [N_PORTS-1:0] p_ren,
  output logic [P_W-1:0]     g_rdata,
  output logic [N_PORTS-1:0] g_err,
  output logic [N_PORTS-1:0] g_ack
);
  for (genvar n = 0; n < N_PORTS; n++) begin : g_port
    localparam logic LIVE = PORT_USED[n];
    logic pick;
    assign pick     = LIVE && hit && (idx == IDX_W'(n));
    assign p_wen[n] = wen & pick;
    assign p_ren[n] = ren & pick;
    // unused slots answer with zero data, no error, standing acknowledge
    assign g_rdata[n*DATA_W +: DATA_W] = LIVE ? p_rdata[n*DATA_W +: DATA_W] : '0;
    assign g_err[n] = LIVE ? p_err[n] : 1'b0;
    assign g_ack[n] = LIVE ? p_ack[n] : 1'b1;
  end
endmodule

// File: rtl/sbd_resp_unit.sv
module sbd_resp_unit #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 3,
  localparam int unsigned P_W = N_PORTS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [P_W-1:0]     g_rdata,
  input  logic [N_PORTS-1:0] g_err,
  input  logic [N_PORTS-1:0] g_ack,
  output logic [DATA_W-1:0]  m_rdata,
  output logic               m_err,
  output logic               m_ack
);
  logic              busy_q;
  logic              miss_q;
  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] pick_data;
  logic              pick_err;
  logic              pick_ack;

  always_comb begin
    pick_data = g_rdata[int'(sel_q)*DATA_W +: DATA_W];
    pick_err  = g_err[sel_q];
    pick_ack  = g_ack[sel_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      miss_q  <= 1'b0;
      sel_q   <= '0;
      m_ack   <= 1'b0;
      m_err   <= 1'b0;
      m_rdata <= '0;
    end else begin
      m_ack   <= 1'b0;
      m_err   <= 1'b0;
      m_rdata <= '0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          miss_q <= !hit;
          sel_q  <= idx;
        end
      end else if (miss_q) begin
        busy_q <= 1'b0;
        m_ack  <= 1'b1;
        m_err  <= 1'b1;
      end else if (pick_ack) begin
        busy_q  <= 1'b0;
        m_ack   <= 1'b1;
        m_err   <= pick_err;
        m_rdata <= pick_data;
      end
    end
  end
endmodule

// File: rtl/sysbus_window_decoder.sv
module sysbus_window_decoder
  import sysbus_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = BUS_W,
  parameter int unsigned DATA_W  = BUS_W,
  parameter int unsigned SEL_W   = DATA_W / 8,
  parameter int unsigned N_PORTS = DEF_PORTS,
  parameter int unsigned WIN_LSB = DEF_WIN_LSB,
  parameter logic [ADDR_W-1:0]  REGION    = DEF_REGION,
  parameter logic [N_PORTS-1:0] PORT_USED = DEF_USED,
  localparam int unsigned IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned P_W   = N_PORTS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  m_addr,
  input  logic [DATA_W-1:0]  m_wdata,
  input  logic [SEL_W-1:0]   m_sel,
  input  logic               m_wen,
  input  logic               m_ren,
  output logic [DATA_W-1:0]  m_rdata,
  output logic               m_err,
  output logic               m_ack,
  output logic [ADDR_W-1:0]  p_addr,
  output logic [DATA_W-1:0]  p_wdata,
  output logic [SEL_W-1:0]   p_sel,
  output logic [N_PORTS-1:0] p_wen,
  output logic [N_PORTS-1:0] p_ren,
  input  logic [P_W-1:0]     p_rdata,
  input  logic [N_PORTS-1:0] p_err,
  input  logic [N_PORTS-1:0] p_ack
);
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [P_W-1:0]     g_rdata;
  logic [N_PORTS-1:0] g_err;
  logic [N_PORTS-1:0] g_ack;

  assign p_addr  = m_addr;
  assign p_wdata = m_wdata;
  assign p_sel   = m_sel;

  sbd_window_match #(
    .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .WIN_LSB(WIN_LSB), .REGION(REGION)
  ) u_match (
    .addr_hi(m_addr[ADDR_W-1:WIN_LSB]),
    .hit    (hit),
    .idx    (idx)
  );

  sbd_port_fanout #(
    .N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_USED(PORT_USED)
  ) u_fan (
    .wen    (m_wen),
    .ren    (m_ren),
    .hit    (hit),
    .idx    (idx),
    .p_rdata(p_rdata),
    .p_err  (p_err),
    .p_ack  (p_ack),
    .p_wen  (p_wen),
    .p_ren  (p_ren),
    .g_rdata(g_rdata),
    .g_err  (g_err),
    .g_ack  (g_ack)
  );

  sbd_resp_unit #(
    .N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_resp (
    .clk    (clk),
    .rst    (rst),
    .start  (m_wen | m_ren),
    .hit    (hit),
    .idx    (idx),
    .g_rdata(g_rdata),
    .g_err  (g_err),
    .g_ack  (g_ack),
    .m_rdata(m_rdata),
    .m_err  (m_err),
    .m_ack  (m_ack)
  );
endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned WIN_LSB = 20,
  parameter logic [ADDR_W-1:0]  REGION    = 32'h4000_0000,
  parameter logic [N_PORTS-1:0] PORT_USED = '1,
  localparam int unsigned IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int unsigned TAG_LSB = WIN_LSB + IDX_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:WIN_LSB] addr_hi,
  input logic                    m_wen,
  input logic                    m_ren,
  input logic [N_PORTS-1:0]      p_wen,
  input logic [N_PORTS-1:0]      p_ren,
  input logic                    m_ack,
  input logic                    m_err,
  input logic [DATA_W-1:0]       m_rdata
);
  logic in_region;
  logic [IDX_W-1:0] slot;
  assign in_region = (addr_hi[ADDR_W-1:TAG_LSB] == REGION[ADDR_W-1:TAG_LSB]);
  assign slot      = addr_hi[TAG_LSB-1:WIN_LSB];

  // R2
  port_strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_wen | p_ren));

  // R2
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_wen | m_ren) |-> ((p_wen | p_ren) == '0));

  // R1
  write_route_chk: assert property (@(posedge clk) disable iff (rst)
    (m_wen && in_region && PORT_USED[slot]) |-> p_wen[slot]);

  // R1
  read_route_chk: assert property (@(posedge clk) disable iff (rst)
    (m_ren && in_region && PORT_USED[slot]) |-> p_ren[slot]);

  // R7
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_region |-> ((p_wen | p_ren) == '0));

  // R6
  unused_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((p_wen | p_ren) & ~PORT_USED) == '0);

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    m_ack |=> !m_ack);

  // R8
  resp_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !m_ack |-> (!m_err && m_rdata == '0));
endmodule

bind sysbus_window_decoder sbd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PORTS(N_PORTS), .WIN_LSB(WIN_LSB),
  .REGION(REGION), .PORT_USED(PORT_USED)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr_hi(m_addr[ADDR_W-1:WIN_LSB]),
  .m_wen  (m_wen),
  .m_ren  (m_ren),
  .p_wen  (p_wen),
  .p_ren  (p_ren),
  .m_ack  (m_ack),
  .m_err  (m_err),
  .m_rdata(m_rdata)
);

// File: tb/tb_sysbus_window_decoder.sv
module tb_sysbus_window_decoder;
  localparam logic [7:0] USED = 8'b0101_1111;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  m_addr = '0, m_wdata = '0;
  logic [3:0]   m_sel = '0;
  logic         m_wen = 1'b0, m_ren = 1'b0;
  logic [31:0]  m_rdata;
  logic         m_err, m_ack;
  logic [31:0]  p_addr, p_wdata;
  logic [3:0]   p_sel;
  logic [7:0]   p_wen, p_ren;
  logic [255:0] p_rdata;
  logic [7:0]   p_err, p_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int lat_cfg = 1;
  logic [7:0] ack_noise = '0;

  always #10 clk = ~clk;

  sysbus_window_decoder #(.PORT_USED(USED)) dut (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_sel(m_sel),
    .m_wen(m_wen), .m_ren(m_ren), .m_rdata(m_rdata), .m_err(m_err), .m_ack(m_ack),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_sel(p_sel), .p_wen(p_wen), .p_ren(p_ren),
    .p_rdata(p_rdata), .p_err(p_err), .p_ack(p_ack)
  );

  function automatic logic [31:0] slave_data(input int n, input logic [31:0] a);
    return {n[3:0], 28'h0} ^ a ^ 32'h00C3_3C00;
  endfunction

  function automatic logic slave_err(input logic [31:0] a);
    return a[19:16] == 4'hE;
  endfunction

  // slave models: ack lat_cfg clocks after the strobe edge
  logic [31:0] cap_addr [8];
  int          cnt [8];
  logic [7:0]  s_ack;

  always @(posedge clk) begin
    for (int n = 0; n < 8; n++) begin
      if (rst) begin
        cnt[n] <= 0; s_ack[n] <= 1'b0; cap_addr[n] <= '0;
      end else begin
        s_ack[n] <= 1'b0;
        if (p_wen[n] | p_ren[n]) begin
          cap_addr[n] <= p_addr;
          cnt[n]      <= lat_cfg - 1;
          s_ack[n]    <= (lat_cfg == 1);
        end else if (cnt[n] > 0) begin
          cnt[n]   <= cnt[n] - 1;
          s_ack[n] <= (cnt[n] == 1);
        end
      end
    end
  end

  always_comb begin
    for (int n = 0; n < 8; n++) begin
      if (USED[n]) begin
        p_rdata[n*32 +: 32] = slave_data(n, cap_addr[n]);
        p_err[n] = slave_err(cap_addr[n]);
        p_ack[n] = s_ack[n] | ack_noise[n];
      end else begin
        p_rdata[n*32 +: 32] = 32'hBAD0_0000 | 32'(n);
        p_err[n] = 1'b1;
        p_ack[n] = ack_noise[n];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic txn(input logic [31:0] a, input bit wr, input int lat,
                     input logic [7:0] noise);
    logic [31:0] wd = $urandom;
    logic [3:0]  sl = 4'($urandom);
    bit inr = (a[31:23] == 9'h080);
    int s = int'(a[22:20]);
    bit live = inr && USED[s];
    int exp_lat = live ? lat : 1;
    logic [31:0] exp_d = live ? slave_data(s, a) : 32'h0;
    bit exp_e = live ? slave_err(a) : !inr;
    logic [7:0] exp_en = live ? (8'b1 << s) : 8'h0;
    string tag = live ? ((lat > 1) ? "R5" : "R4") : (inr ? "R6" : "R7");
    bit early = 0;
    @(negedge clk);
    lat_cfg = lat; m_addr = a; m_wdata = wd; m_sel = sl; m_wen = wr; m_ren = !wr;
    #1;
    chk((wr ? p_wen : p_ren) == exp_en && (wr ? p_ren : p_wen) == 8'h0,
        live ? "R1 R2" : tag, "port strobes", {16'h0, p_wen, p_ren}, {16'h0, exp_en, 8'h0});
    chk(p_addr == a && p_wdata == wd && p_sel == sl, "R3", "forwarded address", p_addr, a);
    @(posedge clk); @(negedge clk);
    m_wen = 1'b0; m_ren = 1'b0; ack_noise = noise & ~(8'b1 << s);
    for (int i = 1; i <= exp_lat; i++) begin
      if (m_ack) early = 1;
      @(posedge clk); @(negedge clk);
    end
    ack_noise = '0;
    chk(!early, tag, "acknowledge came early", 32'(early), 32'h0);
    chk(m_ack === 1'b1, tag, "acknowledge on time", 32'(m_ack), 32'h1);
    chk(m_err === exp_e, exp_e && live ? "R10" : tag, "error flag", 32'(m_err), 32'(exp_e));
    chk(m_rdata === exp_d, tag, "read data", m_rdata, exp_d);
    @(posedge clk); @(negedge clk);
    chk(!m_ack && !m_err && m_rdata == 0, "R8", "response cleared after pulse",
        {m_rdata[29:0], m_err, m_ack}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_ack && !m_err && m_rdata == 0, "R9", "reset outputs", {m_rdata[29:0], m_err, m_ack}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk((p_wen | p_ren) == 0, "R2", "no strobe without request", {24'h0, p_wen | p_ren}, 32'h0);

    txn(32'h4000_0000, 0, 1, 8'h00);
    txn(32'h4030_0104, 1, 3, 8'b0000_0100);
    txn(32'h4050_0000, 0, 1, 8'h00);
    txn(32'h407F_FFFC, 1, 2, 8'hFF);
    txn(32'h406F_FFFC, 0, 2, 8'b1010_0000);
    txn(32'h401E_0010, 0, 4, 8'b0000_0001);
    txn(32'h3FFF_FFFC, 0, 1, 8'h00);
    txn(32'h4080_0000, 1, 1, 8'h00);
    txn(32'hC000_0000, 0, 3, 8'hFF);

    // R9: reset in the middle of a pending request
    @(negedge clk);
    lat_cfg = 4; m_addr = 32'h4020_0040; m_ren = 1'b1;
    @(negedge clk);
    m_ren = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!m_ack && !m_err && m_rdata == 0, "R9", "outputs in reset", {m_rdata[29:0], m_err, m_ack}, 32'h0);
    rst = 1'b0; ack_noise = 8'b0000_0100;
    begin
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (m_ack) seen = 1;
      end
      chk(!seen, "R9", "no acknowledge for dropped request", 32'(seen), 32'h0);
    end
    ack_noise = '0;

    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      int kind = $urandom % 10;
      if (kind < 8) a = {9'h080, 3'($urandom), 18'($urandom), 2'b00};
      else begin
        a = $urandom & 32'hFFFF_FFFC;
        if (a[31:23] == 9'h080) a[31] = 1'b1;
      end
      txn(a, 1'($urandom), 1 + ($urandom % 4), 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule